// File: doc/BRIEF.md
# Serial Audio ADC to Byte FIFO Bridge

The block takes the three-wire serial output of a stereo 24-bit audio converter (bit clock, data line and left/right channel clock) and turns it into a plain byte stream written into an 8-bit parallel USB FIFO. It samples the data line on each rising bit clock, most significant bit first. Every 8 bits it hands a byte to a small write controller, which drives the FIFO write strobe and data bus. Each channel's 24-bit two's complement sample becomes three bytes, high byte first. Within a frame the left sample (channel clock high) comes before the right one.

The stream carries no header and no sync bytes. The receiver finds sample boundaries only because the block starts a stream at a left sample. After reset, and after any byte arrives from the host, the bridge stays silent until it sees a rising channel clock. Host bytes are read out of the FIFO and thrown away. The block runs entirely on its own system clock, which must run at least four times faster than the bit clock. All converter and FIFO inputs pass through synchronisers into that clock domain.

Top module: `adc_byte_bridge`

## Requirements
- R1: While `rst_ni` is low, and afterwards while the converter is idle and no host byte is waiting, `wr_o`, `rd_o`, `data_oe_o` and `overflow_o` are all 0.
- R2: Each 24-bit sample is written as three bytes, bits 23..16 first, then 15..8, then 7..0. A frame writes the left sample (taken while `lrclk_i` is high) and then the right sample (taken while `lrclk_i` is low). Values are passed on unchanged, including the largest positive and most negative values.
- R3: After reset, no byte is written until a rising edge of `lrclk_i` has been seen. Bits sent while `lrclk_i` stays low produce no output.
- R4: A channel's first bit is the one sampled at the first rising `bclk_i` after that channel's `lrclk_i` transition. Bit clocks that follow the 24th bit of a slot are ignored, whatever the level of `sdata_i`, until the next `lrclk_i` transition.
- R5: Each write pulse keeps `wr_o` high for at least 2 system clocks. During the pulse `data_o` does not change and `data_oe_o` is 1. `wr_o` and `rd_o` are never high at the same time.
- R6: No write starts while `tx_full_i` is held high. A byte that completes while the FIFO is full is kept and written, in order, once `tx_full_i` drops, provided that happens before the next byte completes.
- R7: If a byte completes while an earlier byte is still waiting, `overflow_o` goes to 1. Both bytes are dropped, and output resumes with the left sample that follows the next rising `lrclk_i`.
- R8: While `rx_avail_i` is high, the bridge issues exactly one read pulse with `rd_o` high for at least 2 system clocks and `data_oe_o` low. It then drops the rest of the current frame and resumes at the next rising `lrclk_i`.
- R9: `overflow_o` stays at 1 through later correct frames and returns to 0 only on reset or when a host read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Converter bit clock |
| lrclk_i | input | 1 | Channel clock, high for left |
| sdata_i | input | 1 | Serial sample data, MSB first |
| rx_avail_i | input | 1 | FIFO holds a byte from the host |
| tx_full_i | input | 1 | FIFO cannot accept a byte |
| wr_o | output | 1 | FIFO write strobe, active high |
| rd_o | output | 1 | FIFO read strobe, active high |
| data_o | output | 8 | Byte driven to the FIFO |
| data_oe_o | output | 1 | Data bus drive enable |
| overflow_o | output | 1 | Sticky byte-loss flag |

## Verification
On every cycle the assertions check the strobe widths, that data stays stable during a write, that reads and writes are exclusive and that the bus is released during reads. They also check that no write begins while the FIFO has been full for several cycles, and that the overflow flag clears only when a read starts. The byte order, the channel order, alignment to the channel clock, the handling of padding bits, the single-byte hold and the way the stream resumes after overflow or a host byte all depend on whole frames. Only the bench's scenarios can show these.

// File: rtl/adc_bridge_pkg.sv
`timescale 1ns/1ps
package adc_bridge_pkg;

  // Serial capture progress within a frame
  typedef enum logic [1:0] {
    PK_ALIGN   = 2'd0,  // waiting for a rising channel clock
    PK_CAPTURE = 2'd1,  // shifting bits of one channel
    PK_HOLD    = 2'd2   // slot complete, waiting for the next transition
  } pack_state_e;

  // FIFO strobe sequencer
  typedef enum logic [1:0] {
    PT_IDLE  = 2'd0,
    PT_WRITE = 2'd1,
    PT_READ  = 2'd2,
    PT_GAP   = 2'd3   // recovery so the synchronised flags catch up
  } port_state_e;

endpackage

// File: rtl/bridge_rst_sync.sv
`timescale 1ns/1ps
module bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/bridge_sync.sv
`timescale 1ns/1ps
module bridge_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bridge_packer.sv
`timescale 1ns/1ps
module bridge_packer
  import adc_bridge_pkg::*;
#(
  parameter int SAMPLE_BITS = 24,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 bit_stb_i,
  input  logic                 bit_i,
  input  logic                 lr_rise_i,
  input  logic                 lr_fall_i,
  output logic                 byte_stb_o,
  output logic [BYTE_BITS-1:0] byte_o
);

  localparam int BYTES_PER_SAMPLE = SAMPLE_BITS / BYTE_BITS;
  localparam int BIT_CW  = $clog2(BYTE_BITS);
  localparam int BYTE_CW = (BYTES_PER_SAMPLE > 1) ? $clog2(BYTES_PER_SAMPLE) : 1;
  localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(BYTE_BITS - 1);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(BYTES_PER_SAMPLE - 1);

  pack_state_e          state_q, state_d;
  logic                 right_q, right_d;   // 1 while the right slot is current
  logic [BIT_CW-1:0]    bit_cnt_q, bit_cnt_d;
  logic [BYTE_CW-1:0]   byte_cnt_q, byte_cnt_d;
  logic [BYTE_BITS-1:0] shift_q, shift_d;
  logic                 stb_q, stb_d;
  logic [BYTE_BITS-1:0] byte_q, byte_d;

  always_comb begin
    state_d    = state_q;
    right_d    = right_q;
    bit_cnt_d  = bit_cnt_q;
    byte_cnt_d = byte_cnt_q;
    shift_d    = shift_q;
    stb_d      = 1'b0;
    byte_d     = byte_q;
    if (restart_i) begin
      state_d    = PK_ALIGN;
      right_d    = 1'b0;
      bit_cnt_d  = '0;
      byte_cnt_d = '0;
    end else begin
      unique case (state_q)
        PK_ALIGN: begin
          if (lr_rise_i) begin
            state_d    = PK_CAPTURE;
            right_d    = 1'b0;
            bit_cnt_d  = '0;
            byte_cnt_d = '0;
          end
        end
        PK_CAPTURE: begin
          if (bit_stb_i) begin
            shift_d = {shift_q[BYTE_BITS-2:0], bit_i};
            if (bit_cnt_q == LAST_BIT) begin
              stb_d     = 1'b1;
              byte_d    = shift_d;
              bit_cnt_d = '0;
              if (byte_cnt_q == LAST_BYTE) begin
                byte_cnt_d = '0;
                state_d    = PK_HOLD;
              end else begin
                byte_cnt_d = byte_cnt_q + BYTE_CW'(1);
              end
            end else begin
              bit_cnt_d = bit_cnt_q + BIT_CW'(1);
            end
          end
        end
        PK_HOLD: begin
          if (!right_q && lr_fall_i) begin
            state_d = PK_CAPTURE;
            right_d = 1'b1;
          end else if (right_q && lr_rise_i) begin
            state_d = PK_CAPTURE;
            right_d = 1'b0;
          end
        end
        default: state_d = PK_ALIGN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PK_ALIGN;
      right_q    <= 1'b0;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      shift_q    <= '0;
      stb_q      <= 1'b0;
      byte_q     <= '0;
    end else begin
      state_q    <= state_d;
      right_q    <= right_d;
      bit_cnt_q  <= bit_cnt_d;
      byte_cnt_q <= byte_cnt_d;
      shift_q    <= shift_d;
      stb_q      <= stb_d;
      byte_q     <= byte_d;
    end
  end

  assign byte_stb_o = stb_q;
  assign byte_o     = byte_q;

endmodule

// File: rtl/bridge_fifo_port.sv
`timescale 1ns/1ps
module bridge_fifo_port
  import adc_bridge_pkg::*;
#(
  parameter int BYTE_BITS     = 8,
  parameter int STROBE_CYCLES = 2,
  parameter int GAP_CYCLES    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_stb_i,
  input  logic [BYTE_BITS-1:0] byte_i,
  input  logic                 rx_avail_i,
  input  logic                 tx_full_i,
  output logic                 restart_o,
  output logic                 wr_o,
  output logic                 rd_o,
  output logic                 oe_o,
  output logic [BYTE_BITS-1:0] data_o,
  output logic                 overflow_o
);

  localparam int CNT_MAX = (STROBE_CYCLES > GAP_CYCLES) ? STROBE_CYCLES : GAP_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  port_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 pend_vld_q, pend_vld_d;
  logic [BYTE_BITS-1:0] pend_q, pend_d;
  logic [BYTE_BITS-1:0] bus_q, bus_d;
  logic                 ovf_q, ovf_d;
  logic                 host_start, write_start, ovf_evt;

  always_comb begin
    host_start  = (state_q == PT_IDLE) && rx_avail_i;
    write_start = (state_q == PT_IDLE) && !rx_avail_i && pend_vld_q && !tx_full_i;
    ovf_evt     = byte_stb_i && pend_vld_q && !write_start && !host_start;
    restart_o   = host_start || ovf_evt;

    state_d = state_q;
    cnt_d   = cnt_q;
    bus_d   = bus_q;
    unique case (state_q)
      PT_IDLE: begin
        cnt_d = '0;
        if (host_start) begin
          state_d = PT_READ;
        end else if (write_start) begin
          state_d = PT_WRITE;
          bus_d   = pend_q;
        end
      end
      PT_WRITE, PT_READ: begin
        if (cnt_q == STB_LAST) begin
          state_d = PT_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PT_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = PT_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = PT_IDLE;
    endcase

    pend_vld_d = pend_vld_q;
    pend_d     = pend_q;
    if (host_start || ovf_evt) begin
      pend_vld_d = 1'b0;
    end else if (byte_stb_i) begin
      pend_vld_d = 1'b1;
      pend_d     = byte_i;
    end else if (write_start) begin
      pend_vld_d = 1'b0;
    end

    ovf_d = ovf_q;
    if (host_start)   ovf_d = 1'b0;
    else if (ovf_evt) ovf_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PT_IDLE;
      cnt_q      <= '0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      bus_q      <= '0;
      ovf_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      bus_q      <= bus_d;
      ovf_q      <= ovf_d;
    end
  end

  assign wr_o       = (state_q == PT_WRITE);
  assign rd_o       = (state_q == PT_READ);
  assign oe_o       = (state_q == PT_WRITE);
  assign data_o     = bus_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/adc_byte_bridge.sv
`timescale 1ns/1ps
module adc_byte_bridge #(
  parameter int SAMPLE_BITS   = 24,
  parameter int BYTE_BITS     = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int STROBE_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bclk_i,
  input  logic                 lrclk_i,
  input  logic                 sdata_i,
  input  logic                 rx_avail_i,
  input  logic                 tx_full_i,
  output logic                 wr_o,
  output logic                 rd_o,
  output logic [BYTE_BITS-1:0] data_o,
  output logic                 data_oe_o,
  output logic                 overflow_o
);

  localparam int GAP_CYCLES = SYNC_STAGES + 1;
  localparam int SETTLE     = SYNC_STAGES + 1;
  localparam int SET_W      = $clog2(SETTLE + 1);
  localparam int N_SYNC     = 5;

  logic              rst_n;
  logic [N_SYNC-1:0] sync_w;
  logic              s_bclk, s_lr, s_sd, s_rx, s_tx;
  logic              bclk_q, lr_q;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic              settled;
  logic              bit_stb, lr_rise, lr_fall;
  logic              restart;
  logic              byte_stb;
  logic [BYTE_BITS-1:0] byte_w;

  bridge_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  bridge_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({tx_full_i, rx_avail_i, sdata_i, lrclk_i, bclk_i}),
    .q_o    (sync_w)
  );

  assign {s_tx, s_rx, s_sd, s_lr, s_bclk} = sync_w;

  // Edge detection, gated until the synchroniser outputs are meaningful
  always_comb begin
    settled  = (settle_q == SET_W'(SETTLE));
    settle_d = settled ? settle_q : settle_q + SET_W'(1);
    bit_stb  = settled && s_bclk && !bclk_q;
    lr_rise  = settled && s_lr && !lr_q;
    lr_fall  = settled && !s_lr && lr_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      lr_q     <= 1'b0;
      settle_q <= '0;
    end else begin
      bclk_q   <= s_bclk;
      lr_q     <= s_lr;
      settle_q <= settle_d;
    end
  end

  bridge_packer #(.SAMPLE_BITS(SAMPLE_BITS), .BYTE_BITS(BYTE_BITS)) u_packer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .restart_i  (restart),
    .bit_stb_i  (bit_stb),
    .bit_i      (s_sd),
    .lr_rise_i  (lr_rise),
    .lr_fall_i  (lr_fall),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_w)
  );

  bridge_fifo_port #(
    .BYTE_BITS     (BYTE_BITS),
    .STROBE_CYCLES (STROBE_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES)
  ) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .byte_stb_i (byte_stb),
    .byte_i     (byte_w),
    .rx_avail_i (settled && s_rx),
    .tx_full_i  (s_tx),
    .restart_o  (restart),
    .wr_o       (wr_o),
    .rd_o       (rd_o),
    .oe_o       (data_oe_o),
    .data_o     (data_o),
    .overflow_o (overflow_o)
  );

endmodule

// File: rtl/adc_byte_bridge_chk.sv
`timescale 1ns/1ps
module adc_byte_bridge_chk #(
  parameter int BYTE_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tx_full_i,
  input logic                 wr_o,
  input logic                 rd_o,
  input logic [BYTE_BITS-1:0] data_o,
  input logic                 data_oe_o,
  input logic                 overflow_o
);

  AST_WR_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> $past(wr_o, 2)); // R5

  AST_RD_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o) |-> $past(rd_o, 2)); // R8

  AST_WR_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> $stable(data_o)); // R5

  AST_WR_BUS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> data_oe_o); // R5

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o)); // R5

  AST_RD_BUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !data_oe_o); // R8

  // window covers the default two-stage flag synchroniser
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && $past(tx_full_i) && $past(tx_full_i, 2) && $past(tx_full_i, 3)
     && $past(tx_full_i, 4)) |-> !$rose(wr_o)); // R6

  AST_OVF_CLEARS_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overflow_o) |-> $rose(rd_o)); // R9

endmodule

bind adc_byte_bridge adc_byte_bridge_chk #(.BYTE_BITS(BYTE_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_full_i  (tx_full_i),
  .wr_o       (wr_o),
  .rd_o       (rd_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .overflow_o (overflow_o)
);

// File: tb/adc_byte_bridge_test.sv
`timescale 1ns/1ps
module adc_byte_bridge_test;

  localparam int HALF_BCLK = 80;   // bit clock = 1/8 of system clock
  localparam int NVEC = 6;
  // {left, right}: extreme positive/negative, zero/-1, mixed patterns
  localparam logic [47:0] FRAMES [NVEC] = '{
    48'h7FFFFF_800000, 48'h000000_FFFFFF, 48'h123456_ABCDEF,
    48'hA5A5A5_5A5A5A, 48'h000001_FFFFFE, 48'hC0FFEE_0F0F0F
  };

  logic clk = 1'b0;
  logic rst_ni, bclk, lrclk, sdata, rx_avail, tx_full;
  logic wr_o, rd_o, data_oe_o, overflow_o;
  logic [7:0] data_o;

  always #10 clk = ~clk;

  adc_byte_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdata_i(sdata), .rx_avail_i(rx_avail), .tx_full_i(tx_full),
    .wr_o(wr_o), .rd_o(rd_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .overflow_o(overflow_o)
  );

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  logic [7:0] got [0:127];
  int got_n = 0, rd_pulses = 0;
  logic wr_prev = 1'b0, rd_prev = 1'b0;
  int wr_len = 0, rd_len = 0;
  logic [7:0] wr_hold = 8'h00;

  // FIFO-side monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_o) begin
        if (!wr_prev) begin
          got[got_n[6:0]] <= data_o;
          got_n <= got_n + 1;
          wr_hold <= data_o;
          wr_len <= 1;
        end else begin
          wr_len <= wr_len + 1;
          if (data_o !== wr_hold) begin
            mon_fails <= mon_fails + 1;
            $display("FAIL R5 data moved during write: actual %h expected %h", data_o, wr_hold);
          end
        end
        if (data_oe_o !== 1'b1 || rd_o) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R5 bus during write: oe %b rd %b expected oe 1 rd 0", data_oe_o, rd_o);
        end
      end
      if (wr_prev && !wr_o) begin
        mon_checks <= mon_checks + 1;
        if (wr_len < 2) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R5 write width: actual %0d expected >=2", wr_len);
        end
      end
      if (rd_o) begin
        rd_len <= rd_prev ? rd_len + 1 : 1;
        if (!rd_prev) rd_pulses <= rd_pulses + 1;
        if (data_oe_o) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R8 bus driven during read: actual oe 1 expected 0");
        end
      end
      if (rd_prev && !rd_o) begin
        mon_checks <= mon_checks + 1;
        if (rd_len < 2) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R8 read width: actual %0d expected >=2", rd_len);
        end
      end
      wr_prev <= wr_o;
      rd_prev <= rd_o;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_slot(input bit right, input logic [23:0] word);
    for (int b = 0; b < 32; b++) begin
      bclk = 1'b0;
      if (b == 0) lrclk = !right;
      sdata = (b < 24) ? word[23-b] : 1'b1;   // padding bits are ones
      #(HALF_BCLK);
      bclk = 1'b1;
      #(HALF_BCLK);
    end
  endtask

  task automatic send_frame(input logic [47:0] f);
    send_slot(1'b0, f[47:24]);
    send_slot(1'b1, f[23:0]);
  endtask

  task automatic check_word(input string req, input int base, input logic [23:0] w);
    for (int k = 0; k < 3; k++)
      check(req, $sformatf("byte %0d", base + k), int'(got[base + k]), int'(w[23 - 8*k -: 8]));
  endtask

  task automatic host_byte();
    int guard;
    rx_avail = 1'b1;
    guard = 0;
    while (!rd_o && guard < 200) begin @(negedge clk); guard++; end
    while (rd_o && guard < 400) begin @(negedge clk); guard++; end
    rx_avail = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  int base;

  initial begin
    rst_ni = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    rx_avail = 1'b0; tx_full = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "wr in reset", wr_o, 0);
    check("R1", "rd in reset", rd_o, 0);
    check("R1", "oe in reset", data_oe_o, 0);
    check("R1", "ovf in reset", overflow_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", "idle outputs", {wr_o, rd_o, data_oe_o, overflow_o}, 0);

    // R3: bits while channel clock stays low give nothing
    send_slot(1'b1, 24'hABCDEF);
    check("R3", "bytes before rising lrclk", got_n, 0);

    // R2/R4: table of frames, padding ones must be ignored
    for (int i = 0; i < NVEC; i++) begin
      base = got_n;
      send_frame(FRAMES[i]);
      check("R2", "frame byte count", got_n - base, 6);
      check_word("R2", base, FRAMES[i][47:24]);
      check_word("R4", base + 3, FRAMES[i][23:0]);
    end

    // R6: FIFO full while first byte completes; byte held then written
    base = got_n;
    fork
      send_frame(48'h89ABCD_456789);
      begin
        tx_full = 1'b1;
        #2000;
        check("R6", "bytes written while full", got_n - base, 0);
        tx_full = 1'b0;
      end
    join
    check("R6", "frame byte count", got_n - base, 6);
    check_word("R6", base, 24'h89ABCD);
    check_word("R6", base + 3, 24'h456789);
    check("R6", "no overflow", overflow_o, 0);

    // R7: full for a whole frame forces overflow and realignment
    base = got_n;
    tx_full = 1'b1;
    send_frame(48'h111111_222222);
    check("R7", "overflow flag", overflow_o, 1);
    tx_full = 1'b0;
    repeat (30) @(negedge clk);
    check("R7", "dropped bytes stay dropped", got_n - base, 0);
    send_frame(48'h654321_FEDCBA);
    check("R7", "resume byte count", got_n - base, 6);
    check_word("R7", base, 24'h654321);
    check_word("R7", base + 3, 24'hFEDCBA);
    check("R9", "overflow sticky", overflow_o, 1);

    // R8: host byte mid-frame drops the rest, resumes at next rise
    base = got_n;
    fork
      begin send_frame(48'h313233_343536); send_frame(48'h414243_444546); end
      begin
        #5320;
        host_byte();
        check("R9", "overflow cleared by read", overflow_o, 0);
      end
    join
    check("R8", "single read pulse", rd_pulses, 1);
    check("R8", "restart byte count", got_n - base, 9);
    check_word("R8", base, 24'h313233);
    check_word("R8", base + 3, 24'h414243);
    check_word("R8", base + 6, 24'h444546);

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    #2000000;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails + 1);
    $finish;
  end

endmodule